// File: doc/BRIEF.md
# Dual-Slope PWM Timer

A 16-bit timer that sweeps a counter up from zero to a programmable ceiling and back down again. Two compare channels turn that triangular sweep into edge-symmetric pulse-width-modulated waveforms. Compare values written by software go into holding registers. They become active only on the timer tick taken while the counter sits at zero. Every period therefore has equal rising and falling slopes, even when the duty cycle changes while the timer runs.

The ceiling comes from one of two places. It can be the compare-A value, which is buffered in the same way as the compare values. It can instead be a separate ceiling register, which takes effect at once; in that case channel A is free to produce its own waveform. A prescaler sets the count rate as a fraction of the system clock. Four sticky event flags report the zero tick, the two compare matches and the ceiling match. Software clears a flag by writing 1 to its bit. The PWM frequency is f_clk / (2 · N · TOP).

Top module: `dual_slope_pwm`

## Requirements
- R1: Register addresses are 0 control, 1 count (read-only), 2 compare-A holding, 3 compare-B holding, 4 ceiling, 5 flags. Read data is combinational on `addr_i`. After reset the count, all registers, all flags and both waves are zero.
- R2: On each tick the count steps 0,1,…,TOP,TOP-1,…,1,0,1,… so one period is 2·TOP ticks. Between ticks the count holds.
- R3: Writes to addresses 2 and 3 go only to holding registers, which read back at once. The active compare values take the holding values only on a tick where the count is 0.
- R4: Flag bit 0 (zero) is set by the tick at count 0, the same tick that loads the holding values.
- R5: With control bit 3 set, TOP is the active compare-A value, so a new ceiling written to address 2 takes effect only from the next zero tick.
- R6: With control bit 3 clear, TOP is the ceiling register (address 4). A write to it affects the sweep at once. Flag bit 3 is set on a tick where the count equals that ceiling.
- R7: Mode fields are control [5:4] for channel A and [7:6] for channel B. Mode 2 (non-inverted) drives the wave low on an up-slope match and high on a down-slope match, giving 2·C high cycles per 2·TOP cycles. Mode 3 (inverted) is the reverse, giving 2·(TOP−C). Modes 0 and 1 hold the wave low. C = 0 gives 0% and C = TOP gives 100% in mode 2.
- R8: A compare value above TOP never matches. Its wave stays constant and its match flag stays clear.
- R9: Control [2:0] selects one tick every 1, 8, 64, 256 or 1024 clocks for values 1 to 5. Values 0, 6 and 7 stop the count.
- R10: Writing 1 to a bit of address 5 clears that flag; bits written 0 are untouched. A flag set in the same cycle as its clear stays set.
- R11: Flag bit 1 (A match) and flag bit 2 (B match) are set on any tick where the count equals that channel's active compare value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| we_i | input | 1 | Register write strobe |
| addr_i | input | 3 | Register address |
| wdata_i | input | 16 | Register write data |
| rdata_o | output | 16 | Register read data |
| wave_o | output | 2 | PWM waves, bit 0 channel A, bit 1 channel B |
| flags_o | output | 4 | Sticky event flags: zero, A match, B match, ceiling match |

## Verification
The bench builds the block with its default 16-bit counter. It programs ceilings of 5 to 10, so whole triangular periods, duty ratios and buffer hand-overs at zero fit into a few dozen clocks. It runs each divider setting up to 1024 and measures the exact spacing of count changes. The bench lines up register writes with specific count values, including the zero tick itself, to show that holding values wait for zero, that an unbuffered ceiling acts at once, and that a set wins over a simultaneous clear.

// File: rtl/dsp_pkg.sv
`timescale 1ns/1ps
package dsp_pkg;
  localparam int ADDR_W = 3;
  localparam int PRE_W  = 10;
  localparam int NFLG   = 4;

  localparam logic [ADDR_W-1:0] A_CTRL  = 3'd0;
  localparam logic [ADDR_W-1:0] A_COUNT = 3'd1;
  localparam logic [ADDR_W-1:0] A_CMPA  = 3'd2;
  localparam logic [ADDR_W-1:0] A_CMPB  = 3'd3;
  localparam logic [ADDR_W-1:0] A_TOP   = 3'd4;
  localparam logic [ADDR_W-1:0] A_FLAGS = 3'd5;

  localparam int FLG_ZERO = 0;
  localparam int FLG_MA   = 1;
  localparam int FLG_MB   = 2;
  localparam int FLG_TOP  = 3;

  typedef struct packed {
    logic [1:0] mode_b;
    logic [1:0] mode_a;
    logic       top_from_a;
    logic [2:0] clk_sel;
  } ctrl_t;

  // divider - 1 for each select code; select 0/6/7 stops
  function automatic logic [PRE_W-1:0] presc_limit(input logic [2:0] sel);
    case (sel)
      3'd2:    return PRE_W'(7);
      3'd3:    return PRE_W'(63);
      3'd4:    return PRE_W'(255);
      3'd5:    return PRE_W'(1023);
      default: return '0;
    endcase
  endfunction
endpackage

// File: rtl/dsp_prescaler.sv
`timescale 1ns/1ps
module dsp_prescaler import dsp_pkg::*; (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [2:0] sel_i,
  output logic       tick_o
);
  logic [PRE_W-1:0] div_q;
  logic [PRE_W-1:0] lim;
  logic             run;

  assign lim    = presc_limit(sel_i);
  assign run    = (sel_i != 3'd0) && (sel_i <= 3'd5);
  assign tick_o = run && (div_q >= lim);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                div_q <= '0;
    else if (!run || tick_o)    div_q <= '0;
    else                        div_q <= div_q + 1'b1;
  end
endmodule

// File: rtl/dsp_updown.sv
`timescale 1ns/1ps
module dsp_updown #(
  parameter int W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         tick_i,
  input  logic [W-1:0] top_i,
  output logic [W-1:0] cnt_o,
  output logic         up_o
);
  logic [W-1:0] cnt_q;
  logic         down_q;

  // phase of the tick about to be taken
  assign up_o  = (cnt_q == '0) || (!down_q && (cnt_q < top_i));
  assign cnt_o = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      down_q <= 1'b0;
    end else if (tick_i) begin
      if (up_o) begin
        down_q <= 1'b0;
        if (cnt_q < top_i) cnt_q <= cnt_q + 1'b1;
      end else begin
        down_q <= 1'b1;
        cnt_q  <= cnt_q - 1'b1;
      end
    end
  end
endmodule

// File: rtl/dsp_channel.sv
`timescale 1ns/1ps
module dsp_channel #(
  parameter int W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         tick_i,
  input  logic         up_i,
  input  logic [W-1:0] cnt_i,
  input  logic [W-1:0] cmp_i,
  input  logic [1:0]   mode_i,
  output logic         match_o,
  output logic         wave_o
);
  logic pwm_q;

  assign match_o = tick_i && (cnt_i == cmp_i);
  assign wave_o  = mode_i[1] & pwm_q;

  // mode 2: clear rising / set falling; mode 3: reverse
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                     pwm_q <= 1'b0;
    else if (match_o && mode_i[1])   pwm_q <= mode_i[0] ? up_i : !up_i;
  end
endmodule

// File: rtl/dual_slope_pwm.sv
`timescale 1ns/1ps
module dual_slope_pwm import dsp_pkg::*; #(
  parameter int CNT_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [CNT_W-1:0]  wdata_i,
  output logic [CNT_W-1:0]  rdata_o,
  output logic [1:0]        wave_o,
  output logic [NFLG-1:0]   flags_o
);
  localparam int NCH = 2;

  ctrl_t                     ctrl_q;
  logic [CNT_W-1:0]          cap_q;
  logic [NCH-1:0][CNT_W-1:0] buf_q, act_q, cmp_eff;
  logic [NCH-1:0][1:0]       mode;
  logic [NCH-1:0]            match;
  logic [NFLG-1:0]           flags_q, flag_set, flag_clr;
  logic [CNT_W-1:0]          cnt, top_eff;
  logic [2:0]                clk_sel;
  logic                      tick, up, load, top_hit;

  assign clk_sel = ctrl_q.clk_sel;
  assign load    = tick && (cnt == '0);
  assign mode[0] = ctrl_q.mode_a;
  assign mode[1] = ctrl_q.mode_b;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= '0;
      cap_q  <= '0;
    end else if (we_i) begin
      if (addr_i == A_CTRL) ctrl_q <= ctrl_t'(wdata_i[$bits(ctrl_t)-1:0]);
      if (addr_i == A_TOP)  cap_q  <= wdata_i;
    end
  end

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    localparam logic [ADDR_W-1:0] CMP_ADDR = (g == 0) ? A_CMPA : A_CMPB;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        buf_q[g] <= '0;
        act_q[g] <= '0;
      end else begin
        if (we_i && addr_i == CMP_ADDR) buf_q[g] <= wdata_i;
        if (load)                       act_q[g] <= buf_q[g];
      end
    end

    // the zero tick already compares against the value it loads
    assign cmp_eff[g] = load ? buf_q[g] : act_q[g];

    dsp_channel #(.W(CNT_W)) u_ch (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .tick_i  (tick),
      .up_i    (up),
      .cnt_i   (cnt),
      .cmp_i   (cmp_eff[g]),
      .mode_i  (mode[g]),
      .match_o (match[g]),
      .wave_o  (wave_o[g])
    );
  end

  assign top_eff = ctrl_q.top_from_a ? cmp_eff[0] : cap_q;
  assign top_hit = tick && !ctrl_q.top_from_a && (cnt == cap_q);

  dsp_prescaler u_pre (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .sel_i  (clk_sel),
    .tick_o (tick)
  );

  dsp_updown #(.W(CNT_W)) u_cnt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .tick_i (tick),
    .top_i  (top_eff),
    .cnt_o  (cnt),
    .up_o   (up)
  );

  always_comb begin
    flag_set           = '0;
    flag_set[FLG_ZERO] = load;
    flag_set[FLG_MA]   = match[0];
    flag_set[FLG_MB]   = match[1];
    flag_set[FLG_TOP]  = top_hit;
    flag_clr = (we_i && addr_i == A_FLAGS) ? wdata_i[NFLG-1:0] : '0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) flags_q <= '0;
    else         flags_q <= (flags_q & ~flag_clr) | flag_set;
  end
  assign flags_o = flags_q;

  always_comb begin
    case (addr_i)
      A_CTRL:  rdata_o = CNT_W'(ctrl_q);
      A_COUNT: rdata_o = cnt;
      A_CMPA:  rdata_o = buf_q[0];
      A_CMPB:  rdata_o = buf_q[1];
      A_TOP:   rdata_o = cap_q;
      A_FLAGS: rdata_o = CNT_W'(flags_q);
      default: rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/dual_slope_pwm_chk.sv
`timescale 1ns/1ps
module dual_slope_pwm_chk #(
  parameter int W = 16
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             we_i,
  input logic [2:0]       addr_i,
  input logic [1:0]       wave_o,
  input logic [3:0]       flags_o,
  input logic             tick,
  input logic [2:0]       clk_sel,
  input logic [W-1:0]     cnt,
  input logic [1:0][W-1:0] act_q
);
  p_idle_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick |=> $stable(cnt));

  p_step_one_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick |=> (cnt == $past(cnt) + 1'b1) || (cnt == $past(cnt) - 1'b1) ||
             ((cnt == '0) && ($past(cnt) == '0)));

  p_act_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(tick && cnt == '0) |=> $stable(act_q));

  p_zero_flag_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick && cnt == '0) |=> flags_o[0]);

  p_wave_quiet_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tick && !we_i) |=> $stable(wave_o));

  p_stopped_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clk_sel == 3'd0) |-> !tick);

  p_sticky_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(we_i && addr_i == 3'd5) |=> ((flags_o & $past(flags_o)) == $past(flags_o)));
endmodule

bind dual_slope_pwm dual_slope_pwm_chk #(.W(CNT_W)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .we_i    (we_i),
  .addr_i  (addr_i),
  .wave_o  (wave_o),
  .flags_o (flags_o),
  .tick    (tick),
  .clk_sel (clk_sel),
  .cnt     (cnt),
  .act_q   (act_q)
);

// File: tb/dual_slope_pwm_bench.sv
`timescale 1ns/1ps
module dual_slope_pwm_bench;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        we_i = 1'b0;
  logic [2:0]  addr_i = 3'd1;
  logic [15:0] wdata_i = '0;
  logic [15:0] rdata_o;
  logic [1:0]  wave_o;
  logic [3:0]  flags_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #2.5 clk_i = ~clk_i;

  dual_slope_pwm u_dual_slope_pwm (
    .clk_i, .rst_ni, .we_i, .addr_i, .wdata_i, .rdata_o, .wave_o, .flags_o
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic summary();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  function automatic int tri_cnt(input int k, input int t);
    int m = k % (2 * t);
    return (m <= t) ? m : 2 * t - m;
  endfunction

  task automatic do_reset();
    rst_ni = 1'b0; we_i = 1'b0; addr_i = 3'd1; wdata_i = '0;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    we_i = 1'b1; addr_i = a; wdata_i = d;
    @(posedge clk_i);
    @(negedge clk_i);
    we_i = 1'b0; addr_i = 3'd1;
  endtask

  task automatic rd(input logic [2:0] a, output int d);
    addr_i = a;
    #1 d = int'(rdata_o);
    addr_i = 3'd1;
  endtask

  task automatic get_cnt(output int v);
    #1 v = int'(rdata_o);
  endtask

  task automatic wait_up(input int v);
    int p, c;
    get_cnt(p);
    for (int i = 0; i < 5000; i++) begin
      @(negedge clk_i);
      get_cnt(c);
      if (c == v && p == v - 1) break;
      p = c;
    end
  endtask

  task automatic measure(input int n, output int hi_a, output int hi_b);
    hi_a = 0; hi_b = 0;
    repeat (n) begin
      @(negedge clk_i);
      #1;
      hi_a += int'(wave_o[0]);
      hi_b += int'(wave_o[1]);
    end
  endtask

  task automatic peak_to_zero(output int pk);
    int c;
    pk = 0;
    for (int i = 0; i < 5000; i++) begin
      @(negedge clk_i);
      get_cnt(c);
      if (c > pk) pk = c;
      if (c == 0) break;
    end
  endtask

  task automatic t_reset_r1();
    int v;
    do_reset();
    get_cnt(v);   chk(v == 0, "R1", "count after reset", v, 0);
    chk(flags_o == 4'h0, "R1", "flags after reset", int'(flags_o), 0);
    chk(wave_o == 2'b00, "R1", "waves after reset", int'(wave_o), 0);
    rd(3'd0, v);  chk(v == 0, "R1", "control after reset", v, 0);
    rd(3'd4, v);  chk(v == 0, "R1", "ceiling after reset", v, 0);
  endtask

  task automatic t_sweep_r2();
    int v, bad_k, bad_v;
    do_reset();
    wr(3'd4, 16'd5);
    wr(3'd0, 16'h0001);
    bad_k = -1; bad_v = 0;
    for (int k = 0; k < 20; k++) begin
      get_cnt(v);
      if (v != tri_cnt(k, 5) && bad_k < 0) begin bad_k = k; bad_v = v; end
      @(negedge clk_i);
    end
    chk(bad_k < 0, "R2", "triangle sweep TOP=5", bad_v,
        (bad_k < 0) ? 0 : tri_cnt(bad_k, 5));
  endtask

  task automatic t_buffer_r3();
    int v, ha, hb;
    do_reset();
    wr(3'd4, 16'd10);
    wr(3'd2, 16'd3);
    wr(3'd0, 16'h0021);          // sel 1, mode A 2
    repeat (22) @(negedge clk_i);
    wait_up(1);
    wr(3'd2, 16'd7);
    rd(3'd2, v);  chk(v == 7, "R3", "holding readback", v, 7);
    wait_up(6);
    chk(wave_o[0] == 1'b0, "R3", "old compare still active mid-period",
        int'(wave_o[0]), 0);
    wait_up(1);
    measure(20, ha, hb);
    chk(ha == 14, "R3", "new compare after zero tick", ha, 14);
  endtask

  task automatic t_zero_flag_r4();
    int c;
    do_reset();
    wr(3'd4, 16'd6);
    wr(3'd0, 16'h0001);
    repeat (3) @(negedge clk_i);
    wr(3'd5, 16'h000F);
    for (int i = 0; i < 100; i++) begin
      get_cnt(c);
      if (c == 0) break;
      #1;
      chk(flags_o[0] == 1'b0, "R4", "zero flag early", int'(flags_o[0]), 0);
      @(negedge clk_i);
    end
    @(negedge clk_i); #1;
    chk(flags_o[0] == 1'b1, "R4", "zero flag after zero tick", int'(flags_o[0]), 1);
  endtask

  task automatic t_top_a_r5();
    int v, pk, bad_k;
    do_reset();
    wr(3'd2, 16'd6);
    wr(3'd0, 16'h0009);          // sel 1, TOP from A
    bad_k = -1;
    for (int k = 0; k < 24; k++) begin
      get_cnt(v);
      if (v != tri_cnt(k, 6) && bad_k < 0) bad_k = k;
      @(negedge clk_i);
    end
    chk(bad_k < 0, "R5", "sweep with TOP from compare A", bad_k, -1);
    wr(3'd5, 16'h000F);
    wait_up(2);
    wr(3'd2, 16'd4);
    peak_to_zero(pk);
    chk(pk == 6, "R5", "peak before zero tick", pk, 6);
    chk(flags_o[1] == 1'b1, "R5", "A flag at TOP", int'(flags_o[1]), 1);
    peak_to_zero(pk);
    chk(pk == 4, "R5", "peak after zero tick", pk, 4);
  endtask

  task automatic t_top_cap_r6();
    int pk;
    do_reset();
    wr(3'd4, 16'd10);
    wr(3'd0, 16'h0001);
    wait_up(2);
    wr(3'd5, 16'h000F);
    #1 chk(flags_o[3] == 1'b0, "R6", "ceiling flag cleared", int'(flags_o[3]), 0);
    wr(3'd4, 16'd5);
    peak_to_zero(pk);
    chk(pk == 5, "R6", "ceiling acts at once", pk, 5);
    chk(flags_o[3] == 1'b1, "R6", "ceiling flag set", int'(flags_o[3]), 1);
  endtask

  task automatic t_modes_r7();
    int ha, hb;
    do_reset();
    wr(3'd4, 16'd10);
    wr(3'd2, 16'd4);
    wr(3'd3, 16'd4);
    wr(3'd0, 16'h00E1);          // A mode 2, B mode 3
    repeat (20) @(negedge clk_i);
    measure(20, ha, hb);
    chk(ha == 8,  "R7", "non-inverted C=4 TOP=10", ha, 8);
    chk(hb == 12, "R7", "inverted C=4 TOP=10", hb, 12);
    wr(3'd2, 16'd0);
    wr(3'd3, 16'd10);
    wr(3'd0, 16'h00A1);          // both mode 2
    repeat (40) @(negedge clk_i);
    measure(20, ha, hb);
    chk(ha == 0,  "R7", "C=0 gives 0%", ha, 0);
    chk(hb == 20, "R7", "C=TOP gives 100%", hb, 20);
    wr(3'd0, 16'h0081);          // A mode 0
    measure(20, ha, hb);
    chk(ha == 0, "R7", "mode 0 holds low", ha, 0);
  endtask

  task automatic t_above_r8();
    int ha, hb;
    do_reset();
    wr(3'd4, 16'd10);
    wr(3'd3, 16'd20);
    wr(3'd0, 16'h0081);          // B mode 2
    repeat (25) @(negedge clk_i);
    wr(3'd5, 16'h000F);
    measure(40, ha, hb);
    chk(hb == 0, "R8", "wave B constant", hb, 0);
    chk(flags_o[2] == 1'b0, "R8", "B flag never set", int'(flags_o[2]), 0);
  endtask

  task automatic t_presc_r9(input logic [2:0] sel, input int div);
    int p, c, n;
    do_reset();
    wr(3'd4, 16'd200);
    wr(3'd0, {13'd0, sel});
    get_cnt(p);
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk_i); get_cnt(c);
      if (c != p) break;
    end
    p = c; n = 0;
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk_i); get_cnt(c); n++;
      if (c != p) break;
    end
    chk(n == div, "R9", $sformatf("tick spacing sel %0d", sel), n, div);
  endtask

  task automatic t_stop_r9(input logic [2:0] sel);
    int c0, c;
    do_reset();
    wr(3'd4, 16'd200);
    wr(3'd0, 16'h0001);
    repeat (5) @(negedge clk_i);
    wr(3'd0, {13'd0, sel});
    get_cnt(c0);
    repeat (30) @(negedge clk_i);
    get_cnt(c);
    chk(c == c0, "R9", $sformatf("count frozen sel %0d", sel), c, c0);
  endtask

  task automatic t_flags_r10();
    int c, prev;
    do_reset();
    wr(3'd4, 16'd10);
    wr(3'd0, 16'h0001);
    repeat (5) @(negedge clk_i);
    for (int i = 0; i < 100; i++) begin
      get_cnt(c);
      if (c == 0) break;
      @(negedge clk_i);
    end
    wr(3'd5, 16'h0001);          // lands on the zero tick
    #1 chk(flags_o[0] == 1'b1, "R10", "set wins over clear", int'(flags_o[0]), 1);
    prev = int'(flags_o);
    wr(3'd5, 16'h0001);
    #1 chk(int'(flags_o) == (prev & 14), "R10", "clear bit 0 only",
           int'(flags_o), prev & 14);
  endtask

  task automatic t_match_r11();
    do_reset();
    wr(3'd4, 16'd10);
    wr(3'd3, 16'd4);
    wr(3'd0, 16'h0001);
    repeat (25) @(negedge clk_i);
    wr(3'd5, 16'h000F);
    repeat (20) @(negedge clk_i);
    #1 chk(flags_o[2] == 1'b1, "R11", "B match flag", int'(flags_o[2]), 1);
  endtask

  initial begin
    t_reset_r1();
    t_sweep_r2();
    t_buffer_r3();
    t_zero_flag_r4();
    t_top_a_r5();
    t_top_cap_r6();
    t_modes_r7();
    t_above_r8();
    t_presc_r9(3'd2, 8);
    t_presc_r9(3'd3, 64);
    t_presc_r9(3'd4, 256);
    t_presc_r9(3'd5, 1024);
    t_stop_r9(3'd0);
    t_stop_r9(3'd6);
    t_flags_r10();
    t_match_r11();
    summary();
  end

  initial begin
    repeat (200000) @(posedge clk_i);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual 1 expected 0");
    summary();
  end
endmodule